// File: doc/BRIEF.md
# SD Card Data FIFO Engine

This block sits between a 32-bit software data register and a byte-wide card data port of an SD host. It holds a 16-word circular FIFO and a remaining-byte counter. Writing the block-count register loads that counter with block count times block size. While the transfer direction is read, the engine takes bytes from the card and packs them into words, lowest byte lane first, and pushes each word into the FIFO. Software then pops the words. While the direction is write, software pushes words, and the engine pops them and sends them to the card one byte at a time, low byte first.

The engine sets sticky status bits: a data flag for each word it moves, a data interrupt when that interrupt is enabled, and a block interrupt during writes when the remaining count reaches a multiple of the block size. A debug word shows the live FIFO fill level in bits 8:4 and a 4-bit transfer-state nibble in bits 3:0. The nibble changes to 0x1 when the remaining count reaches zero.

Software accesses use single-cycle strobes: the push strobe and the pop strobe. Each card port is a valid/ready byte stream, and a byte moves on a cycle where valid and ready are both high.
- **Card-to-host stream:** `card_rx_ready` is high only while the direction is read, bytes remain, and the FIFO is not full. A full FIFO therefore holds off the card.
- **Host-to-card stream:** `card_tx_valid` is high only while the direction is write, bytes remain, and a byte is held or the FIFO has a word. The card may hold `card_tx_ready` low for any number of cycles, and the offered byte stays the same while it does.

Top module: `sd_data_fifo_engine`

## Requirements
- R1: The FIFO keeps 16 words in order. A software push while it holds 16 words is discarded, and the fill level stays 16.
- R2: A software pop while the FIFO is empty returns 0x00000000 and leaves the fill level at 0.
- R3: A block-count write loads the remaining count with block count × block size. Exactly that many bytes then cross the card port, and afterwards the card-side handshake stays idle.
- R4: In a read, byte k of each group of four goes to bits 8k+7:8k of the pushed word. The first byte goes to bits 7:0.
- R5: When the count runs out in mid-word during a read, the partial word is still pushed, with its unfilled upper lanes zero.
- R6: A read moves a byte only while `card_rx_valid` is high. `card_rx_ready` is low while the FIFO holds 16 words.
- R7: In a write, each popped word is sent low byte first, and each byte sent lowers the remaining count by one. `card_tx_valid` goes low once the count is zero, even if unsent bytes are still held.
- R8: Each word the engine pushes or pops sets status bit 0. If `cfg_data_irq_en` is high, it also sets status bit 8.
- R9: In a write with a nonzero block size, a byte that leaves the remaining count at a multiple of the block size sets status bit 9 when `cfg_block_irq_en` is high. `irq` is high whenever status bit 8 or bit 9 is set.
- R10: When a transfer byte brings the remaining count to zero, debug bits 3:0 become 0x1.
- R11: Debug bits 8:4 always equal the current FIFO fill level.
- R12: After reset the debug word reads 0x0000C60F. A debug write stores every bit except 8:4, and a written low nibble of 0xF is stored as 0x0.
- R13: Status bits are cleared by writing 1 to them through `status_clr`. A set and a clear of the same bit in one cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_read | input | 1 | Transfer direction is card to host (takes priority) |
| xfer_write | input | 1 | Transfer direction is host to card |
| cfg_data_irq_en | input | 1 | Enables status bit 8 on word moves |
| cfg_block_irq_en | input | 1 | Enables status bit 9 on block boundaries |
| blk_size | input | 12 | Block size in bytes |
| blk_cnt_we | input | 1 | Block-count write strobe; loads the remaining count |
| blk_cnt_wdata | input | 9 | Block count |
| sw_wr_en | input | 1 | Software data-register write (push) |
| sw_wr_data | input | 32 | Word to push |
| sw_rd_en | input | 1 | Software data-register read (pop) |
| sw_rd_data | output | 32 | FIFO head, or zero if empty |
| card_rx_valid | input | 1 | Card offers a byte (data ready) |
| card_rx_ready | output | 1 | Engine accepts a card byte |
| card_rx_data | input | 8 | Byte from the card |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| card_tx_data | output | 8 | Byte to the card |
| status_clr | input | 10 | Write-one-to-clear mask for status |
| status_q | output | 10 | Status: bit 0 data flag, bit 8 data interrupt, bit 9 block interrupt |
| irq | output | 1 | Interrupt request |
| dbg_we | input | 1 | Debug word write strobe |
| dbg_wdata | input | 32 | Debug write value |
| dbg_q | output | 32 | Debug word with live fill level in bits 8:4 |

## Verification
The read path is tested three ways:
- **Whole multiple of four bytes:** confirms lane order.
- **Count ending mid-word:** shows whether the partial word is pushed with zeroed upper lanes.
- **Transfer longer than the FIFO:** shows whether the engine stalls at 16 words without dropping or reordering, then resumes after software drains it.

The write path sends two words under a card that inserts ready gaps. This separates low-byte-first ordering from the handling of bytes beyond the count. It also pins the block interrupt to the exact byte that crosses a block boundary. Software-only pushes and pops past full and past empty test the drop and zero-return rules apart from the engine.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int ST_W        = 10;
  localparam int ST_DATA     = 0;
  localparam int ST_DATA_IRQ = 8;
  localparam int ST_BLK_IRQ  = 9;
  localparam int FILL_LO     = 4;
  localparam int FILL_W      = 5;
  localparam logic [31:0] DBG_RESET = 32'h0000_C60F;
  localparam logic [3:0]  MODE_DATA = 4'h1;
  localparam logic [3:0]  MODE_OFF  = 4'hF;
endpackage

// File: rtl/sdf_ring.sv
module sdf_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic             do_push, do_pop;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  // R1: a push into a full ring with no pop leaves it full
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> full);
  // R2: a pop from an empty ring with no push leaves it empty
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> empty);
endmodule

// File: rtl/sdf_rx_pack.sv
module sdf_rx_pack #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_fire,
  input  logic [7:0]        byte_data,
  input  logic              last,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam int LANES = WORD_W / 8;
  localparam int IDX_W = $clog2(LANES);

  logic [WORD_W-1:0] acc;
  logic [IDX_W-1:0]  idx;

  assign word_data  = acc | ({{(WORD_W-8){1'b0}}, byte_data} << (8 * idx));
  assign word_valid = byte_fire & ((idx == IDX_W'(LANES-1)) | last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc <= '0;
      idx <= '0;
    end else if (byte_fire) begin
      if (word_valid) begin
        acc <= '0;
        idx <= '0;
      end else begin
        acc <= word_data;
        idx <= idx + 1'b1;
      end
    end
  end

  // R5: after a word leaves, the next byte starts at lane 0
  p_lane_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> (idx == '0) && (acc == '0));
endmodule

// File: rtl/sdf_tx_unpack.sv
module sdf_tx_unpack #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enable,
  input  logic [WORD_W-1:0] head,
  input  logic              fifo_empty,
  input  logic              byte_ready,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  output logic              word_pop
);
  localparam int LANES  = WORD_W / 8;
  localparam int LEFT_W = $clog2(LANES);

  logic [WORD_W-1:0] shreg;
  logic [LEFT_W-1:0] left;
  logic              have, fire;

  assign have       = (left != '0);
  assign byte_valid = enable & (have | ~fifo_empty);
  assign byte_data  = have ? shreg[7:0] : head[7:0];
  assign fire       = byte_valid & byte_ready;
  assign word_pop   = fire & ~have;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      shreg <= '0;
      left  <= '0;
    end else if (fire) begin
      if (have) begin
        shreg <= shreg >> 8;
        left  <= left - 1'b1;
      end else begin
        shreg <= head >> 8;
        left  <= LEFT_W'(LANES-1);
      end
    end
  end

  // R7: taking a fresh word leaves its upper bytes queued next, next-lowest first
  p_lsb_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_pop && !clr |=> have && (shreg[7:0] == $past(head[15:8])));
endmodule

// File: rtl/sd_data_fifo_engine.sv
module sd_data_fifo_engine
  import sdf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 12,
  parameter int BCNT_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_read,
  input  logic               xfer_write,
  input  logic               cfg_data_irq_en,
  input  logic               cfg_block_irq_en,
  input  logic [SIZE_W-1:0]  blk_size,
  input  logic               blk_cnt_we,
  input  logic [BCNT_W-1:0]  blk_cnt_wdata,
  input  logic               sw_wr_en,
  input  logic [31:0]        sw_wr_data,
  input  logic               sw_rd_en,
  output logic [31:0]        sw_rd_data,
  input  logic               card_rx_valid,
  output logic               card_rx_ready,
  input  logic [7:0]         card_rx_data,
  output logic               card_tx_valid,
  input  logic               card_tx_ready,
  output logic [7:0]         card_tx_data,
  input  logic [ST_W-1:0]    status_clr,
  output logic [ST_W-1:0]    status_q,
  output logic               irq,
  input  logic               dbg_we,
  input  logic [31:0]        dbg_wdata,
  output logic [31:0]        dbg_q
);
  localparam int WORD_W = 32;
  localparam int REM_W  = SIZE_W + BCNT_W;
  localparam int LVL_W  = $clog2(DEPTH+1);

  logic              rd_mode, wr_mode, rem_nz, last;
  logic              rx_fire, tx_fire, done_evt, blk_hit;
  logic              eng_push, eng_pop, fifo_push, fifo_pop;
  logic              fifo_full, fifo_empty;
  logic [WORD_W-1:0] rx_word, head, push_data;
  logic [LVL_W-1:0]  level;
  logic [REM_W-1:0]  remaining;
  logic [SIZE_W-1:0] size_q, blk_pos;
  logic [31:0]       dbg_r;

  assign rd_mode  = xfer_read;
  assign wr_mode  = xfer_write & ~xfer_read;
  assign rem_nz   = (remaining != '0);
  assign last     = (remaining == REM_W'(1));

  assign card_rx_ready = rd_mode & rem_nz & ~fifo_full;
  assign rx_fire       = card_rx_valid & card_rx_ready;
  assign tx_fire       = card_tx_valid & card_tx_ready;
  assign done_evt      = (rx_fire | tx_fire) & last;
  assign blk_hit       = tx_fire & (size_q != '0) & (blk_pos == SIZE_W'(1));

  sdf_rx_pack #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(blk_cnt_we),
    .byte_fire(rx_fire), .byte_data(card_rx_data), .last(last),
    .word_valid(eng_push), .word_data(rx_word)
  );

  sdf_tx_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .clr(blk_cnt_we),
    .enable(wr_mode & rem_nz), .head(head), .fifo_empty(fifo_empty),
    .byte_ready(card_tx_ready), .byte_valid(card_tx_valid),
    .byte_data(card_tx_data), .word_pop(eng_pop)
  );

  // engine moves win over software access in the same cycle
  assign fifo_push  = eng_push | sw_wr_en;
  assign push_data  = eng_push ? rx_word : sw_wr_data;
  assign fifo_pop   = eng_pop | sw_rd_en;
  assign sw_rd_data = (fifo_empty | eng_pop) ? '0 : head;

  sdf_ring #(.DEPTH(DEPTH), .W(WORD_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(push_data),
    .pop(fifo_pop), .head(head), .level(level),
    .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      size_q    <= '0;
      blk_pos   <= '0;
    end else if (blk_cnt_we) begin
      remaining <= REM_W'(blk_cnt_wdata) * REM_W'(blk_size);
      size_q    <= blk_size;
      blk_pos   <= blk_size;
    end else begin
      if (rx_fire || tx_fire) remaining <= remaining - 1'b1;
      if (tx_fire) blk_pos <= (blk_pos == SIZE_W'(1)) ? size_q : blk_pos - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      for (int i = 0; i < ST_W; i++) begin
        if (status_clr[i]) status_q[i] <= 1'b0;
      end
      if (eng_push || eng_pop) begin
        status_q[ST_DATA] <= 1'b1;
        if (cfg_data_irq_en) status_q[ST_DATA_IRQ] <= 1'b1;
      end
      if (blk_hit && cfg_block_irq_en) status_q[ST_BLK_IRQ] <= 1'b1;
    end
  end

  assign irq = status_q[ST_DATA_IRQ] | status_q[ST_BLK_IRQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_r <= DBG_RESET;
    end else if (dbg_we) begin
      dbg_r <= (dbg_wdata[3:0] == MODE_OFF) ? {dbg_wdata[31:4], 4'h0} : dbg_wdata;
    end else if (done_evt) begin
      dbg_r[3:0] <= MODE_DATA;
    end
  end

  assign dbg_q = {dbg_r[31:FILL_LO+FILL_W], FILL_W'(level), dbg_r[FILL_LO-1:0]};

  // R3: each card byte lowers the remaining count by exactly one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire || tx_fire) && !blk_cnt_we |=> remaining == $past(remaining) - 1'b1);
  // R6: with no card byte offered, a read transfer holds its count
  p_rx_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode && !card_rx_valid && !blk_cnt_we |=> remaining == $past(remaining));
  // R8: every engine word move leaves the data flag set
  p_data_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_push || eng_pop |=> status_q[ST_DATA]);
  // R9: a block boundary with the enable raises the block interrupt
  p_block_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hit && cfg_block_irq_en |=> status_q[ST_BLK_IRQ] && irq);
  // R10: the last byte puts the state nibble in data mode
  p_data_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !dbg_we && !blk_cnt_we |=> dbg_q[3:0] == MODE_DATA);
  // R12: a written nibble of 0xF is stored as zero
  p_nibble_fold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we && dbg_wdata[3:0] == MODE_OFF |=> dbg_q[3:0] == 4'h0);
endmodule

// File: tb/sd_data_fifo_engine_tb.sv
module sd_data_fifo_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_read = 1'b0, xfer_write = 1'b0;
  logic        cfg_data_irq_en = 1'b0, cfg_block_irq_en = 1'b0;
  logic [11:0] blk_size = '0;
  logic        blk_cnt_we = 1'b0;
  logic [8:0]  blk_cnt_wdata = '0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic        sw_rd_en = 1'b0;
  logic [31:0] sw_rd_data;
  logic        card_rx_valid = 1'b0, card_rx_ready;
  logic [7:0]  card_rx_data = '0;
  logic        card_tx_valid, card_tx_ready = 1'b0;
  logic [7:0]  card_tx_data;
  logic [9:0]  status_clr = '0, status_q;
  logic        irq;
  logic        dbg_we = 1'b0;
  logic [31:0] dbg_wdata = '0, dbg_q;

  int checks = 0, errors = 0;
  logic [31:0] exp_words [$];
  logic [7:0]  exp_bytes [$];

  always #5 clk = ~clk;

  sd_data_fifo_engine dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_read(xfer_read), .xfer_write(xfer_write),
    .cfg_data_irq_en(cfg_data_irq_en), .cfg_block_irq_en(cfg_block_irq_en),
    .blk_size(blk_size), .blk_cnt_we(blk_cnt_we), .blk_cnt_wdata(blk_cnt_wdata),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .sw_rd_en(sw_rd_en),
    .sw_rd_data(sw_rd_data), .card_rx_valid(card_rx_valid),
    .card_rx_ready(card_rx_ready), .card_rx_data(card_rx_data),
    .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
    .card_tx_data(card_tx_data), .status_clr(status_clr), .status_q(status_q),
    .irq(irq), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_q(dbg_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dbg_model(input logic [31:0] stored, input int fill);
    return (stored & ~32'h1F0) | (32'(fill) << 4);
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  // driver: queue the words a read of n card bytes must yield (R4, R5)
  task automatic expect_packed(input int first, input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) begin
      w = w | (32'(pat(first + i)) << (8 * (i % 4)));
      if (i % 4 == 3 || i == n - 1) begin
        exp_words.push_back(w);
        w = '0;
      end
    end
  endtask

  task automatic sw_write(input logic [31:0] d);
    @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = d;
    @(negedge clk); sw_wr_en = 1'b0;
  endtask

  task automatic sw_read_check(input string req);
    logic [31:0] e;
    e = (exp_words.size() != 0) ? exp_words.pop_front() : 32'h0;
    @(negedge clk); sw_rd_en = 1'b1;
    #1 chk(req, sw_rd_data, e);
    @(negedge clk); sw_rd_en = 1'b0;
  endtask

  task automatic load_blocks(input int size, input int cnt);
    @(negedge clk); blk_size = 12'(size); blk_cnt_wdata = 9'(cnt); blk_cnt_we = 1'b1;
    @(negedge clk); blk_cnt_we = 1'b0;
  endtask

  task automatic feed_byte(input logic [7:0] b);
    @(negedge clk); card_rx_valid = 1'b1; card_rx_data = b;
    forever begin
      #1;
      if (card_rx_ready) break;
      @(negedge clk);
    end
    @(negedge clk); card_rx_valid = 1'b0;
  endtask

  task automatic take_byte();
    @(negedge clk); card_tx_ready = 1'b1;
    forever begin
      #1;
      if (card_tx_valid) break;
      @(negedge clk);
    end
    @(negedge clk); card_tx_ready = 1'b0;
  endtask

  // monitor: compares each byte handed to the card against the scoreboard (R7)
  initial begin
    forever begin
      @(negedge clk); #3;
      if (card_tx_valid && card_tx_ready) begin
        if (exp_bytes.size() != 0) chk("R7 byte order", 32'(card_tx_data), 32'(exp_bytes.pop_front()));
        else chk("R7 unexpected byte", 32'(card_tx_data), 32'hFFFF_FFFF);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] dbg_store;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12: reset value of the debug word
    chk("R12 debug reset", dbg_q, 32'h0000_C60F);
    chk("R13 status reset", 32'(status_q), 32'h0);
    chk("R3 rx idle at reset", 32'(card_rx_ready), 32'h0);
    chk("R7 tx idle at reset", 32'(card_tx_valid), 32'h0);

    // R2: pop on empty returns zero
    sw_read_check("R2 empty pop");
    #1 chk("R2 level stays 0", 32'(dbg_q[8:4]), 32'd0);

    // R1: 17 pushes, the last dropped; order kept
    for (int i = 0; i < 17; i++) begin
      sw_write(32'h5A00_0000 + 32'(i));
      if (i < 16) exp_words.push_back(32'h5A00_0000 + 32'(i));
    end
    #1 chk("R1 level 16 (R11)", 32'(dbg_q[8:4]), 32'd16);
    for (int i = 0; i < 16; i++) sw_read_check("R1 fifo order");
    sw_read_check("R2 pop after drain");
    #1 chk("R11 level back to 0", 32'(dbg_q[8:4]), 32'd0);

    // R12: nibble 0xF folds to 0; fill lane is not writable
    @(negedge clk); dbg_we = 1'b1; dbg_wdata = 32'h1234_567F;
    @(negedge clk); dbg_we = 1'b0; #1;
    chk("R12 nibble F stored as 0", dbg_q, 32'h1234_5600);
    @(negedge clk); dbg_we = 1'b1; dbg_wdata = 32'h0000_00A5;
    @(negedge clk); dbg_we = 1'b0; #1;
    dbg_store = 32'h0000_00A5;
    chk("R12 nibble kept", dbg_q, dbg_model(dbg_store, 0));

    // R4/R5/R6: read of 6 bytes, gaps included
    xfer_read = 1'b1; cfg_data_irq_en = 1'b1;
    load_blocks(6, 1);
    expect_packed(0, 6);
    feed_byte(pat(0)); feed_byte(pat(1));
    repeat (3) @(negedge clk);
    #1 chk("R6 waits for card data", 32'(card_rx_ready), 32'h1);
    chk("R6 no word yet", 32'(dbg_q[8:4]), 32'd0);
    for (int i = 2; i < 6; i++) feed_byte(pat(i));
    #1;
    chk("R3 handshake idle after count", 32'(card_rx_ready), 32'h0);
    chk("R10 data mode and R11 fill", dbg_q, dbg_model({dbg_store[31:4], 4'h1}, 2));
    chk("R8 data flag and data irq", 32'(status_q), 32'h101);
    chk("R8 irq line", 32'(irq), 32'h1);
    sw_read_check("R4 little-endian lanes");
    sw_read_check("R5 partial word");

    // R13: write-one-to-clear
    @(negedge clk); status_clr = 10'h101;
    @(negedge clk); status_clr = '0; #1;
    chk("R13 status cleared", 32'(status_q), 32'h0);
    chk("R13 irq cleared", 32'(irq), 32'h0);

    // R6: 72-byte read stalls at 16 words
    load_blocks(8, 9);
    expect_packed(100, 72);
    for (int i = 0; i < 64; i++) feed_byte(pat(100 + i));
    #1 chk("R6 ready low when full", 32'(card_rx_ready), 32'h0);
    chk("R1 level 16 during stall", 32'(dbg_q[8:4]), 32'd16);
    for (int i = 0; i < 16; i++) sw_read_check("R6 stalled words intact");
    for (int i = 64; i < 72; i++) feed_byte(pat(100 + i));
    #1 chk("R3 exact 72 bytes", 32'(card_rx_ready), 32'h0);
    sw_read_check("R4 resumed word");
    sw_read_check("R4 final word");

    // R7/R9/R10: write of 2 blocks of 3 bytes
    xfer_read = 1'b0; xfer_write = 1'b1; cfg_data_irq_en = 1'b0; cfg_block_irq_en = 1'b1;
    sw_write(32'hA1B2_C3D4); sw_write(32'h7788_5566);
    exp_bytes.push_back(8'hD4); exp_bytes.push_back(8'hC3); exp_bytes.push_back(8'hB2);
    exp_bytes.push_back(8'hA1); exp_bytes.push_back(8'h66); exp_bytes.push_back(8'h55);
    @(negedge clk); dbg_we = 1'b1; dbg_wdata = 32'h0;
    status_clr = 10'h3FF;
    @(negedge clk); dbg_we = 1'b0; status_clr = '0; #1;
    chk("R11 two words queued", dbg_q, 32'h0000_0020);
    chk("R7 no byte before load", 32'(card_tx_valid), 32'h0);
    load_blocks(3, 2);
    take_byte(); take_byte();
    #1 chk("R9 no block irq mid-block", 32'(status_q[9]), 32'h0);
    take_byte();
    #1 chk("R9 block irq at boundary", 32'(status_q[9]), 32'h1);
    chk("R9 irq line", 32'(irq), 32'h1);
    take_byte(); take_byte(); take_byte();
    #1;
    chk("R7 valid low after count", 32'(card_tx_valid), 32'h0);
    chk("R10 data mode and R11 empty", dbg_q, 32'h0000_0001);
    chk("R8 data flag, data irq off", 32'(status_q), 32'h201);
    chk("R7 all bytes sent", 32'(exp_bytes.size()), 32'h0);
    finish_run();
  end
endmodule